// File: doc/BRIEF.md
# Row De-interleaving Pixel Packer

The block sits between a sensor receiver and an interleaved memory writer. Every input beat is a 64-bit word carrying four pixels: two adjacent pixels of the current even row and two adjacent pixels of the current odd row. The block splits each beat into an even-row lane and an odd-row lane, so that software later sees each row as one contiguous run instead of columns mixed between two rows.

Each lane reformats its pixel pair according to the converter resolution. At 10 and 12 bits a pair is squeezed into three bytes, which removes the padding that would otherwise waste a quarter or more of the bus. At 14 bits each pixel keeps a 16-bit slot. The lane gathers these 3- or 4-byte units into 64-bit words. A word is complete when eight bytes are present. At the end of a line the lane pushes out whatever is left as a short word and reports how many bytes it holds. Every output word carries its lane's row-parity tag and an end-of-line flag.

Top module: `row_deinterleave_packer`

## Requirements
- R1: While `rst_n` is low, and from its release until the first accepted beat has gone through, `ev_valid` and `od_valid` are low.
- R2: In a beat, bits [15:0] and [31:16] are pixel 0 and pixel 1 of the even row, and bits [47:32] and [63:48] are pixel 0 and pixel 1 of the odd row. Each pixel is right-aligned in its 16-bit slot.
- R3: With `mode` 2 or 3 (14-bit), a beat contributes 4 bytes: pixel 0 masked to 14 bits in a 16-bit slot, then pixel 1 the same way. The top two bits of each slot are zero.
- R4: With `mode` 1 (12-bit), a beat contributes 3 bytes. Byte 0 is pixel 0 bits [7:0]. Byte 1 holds pixel 0 bits [11:8] in its low nibble and pixel 1 bits [3:0] in its high nibble. Byte 2 is pixel 1 bits [11:4].
- R5: With `mode` 0 (10-bit), each pixel's bits [9:0] are shifted left by two to form a 12-bit value, which is then packed as in R4.
- R6: The bytes of a lane fill output words from byte 0 (bits [7:0]) upward, in arrival order, without gaps. A word that is not the last of its line holds 8 bytes. It appears on the clock edge that accepts the beat which completes it.
- R7: The last word of a line has the `*_eol` flag set. `*_bytes` gives its count of valid bytes (1 to 8), and the bytes above that count are zero.
- R8: When the final beat of a line overflows a word, the full word (8 bytes, no eol) appears on that beat's edge. The remainder, with eol, appears one cycle later.
- R9: A remainder from R8 and a beat of the following line may fall into the same cycle, even if that beat ends a one-beat line. No word is lost, words stay in order, and the input is never stalled.
- R10: With `in_valid` low, `in_data`, `in_eol` and `mode` have no effect. Pixel bits above the selected resolution do not reach the output.
- R11: `ev_par` is 0 and `od_par` is 1. Both lanes emit words in the same cycles, with equal byte counts and eol flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode | input | 2 | Resolution: 0 = 10-bit, 1 = 12-bit, 2 or 3 = 14-bit |
| in_valid | input | 1 | Beat present |
| in_eol | input | 1 | Beat is the last of the line pair |
| in_data | input | 64 | Four pixels, layout per R2 |
| ev_valid | output | 1 | Even-lane word valid |
| ev_eol | output | 1 | Even-lane word ends the row |
| ev_bytes | output | 4 | Valid bytes in the even-lane word |
| ev_data | output | 64 | Even-lane packed word |
| ev_par | output | 1 | Row-parity tag of the even lane |
| od_valid | output | 1 | Odd-lane word valid |
| od_eol | output | 1 | Odd-lane word ends the row |
| od_bytes | output | 4 | Valid bytes in the odd-lane word |
| od_data | output | 64 | Odd-lane packed word |
| od_par | output | 1 | Row-parity tag of the odd lane |

## Verification
Two things can fall into one cycle: sending out the held-back remainder of a line that overflowed its last word, and accepting the first beat of the next line, which may itself end a one-beat line and create a new short word. A directed sequence sends a 12-bit line of three beats (9 bytes) and follows it at once with a one-beat line. The bench expects three words on three consecutive cycles: 8 bytes, then 1 byte with eol, then 3 bytes with eol. Random lines of 1 to 10 beats, with random resolution, gaps and back-to-back line ends, run into the same collision many times. A byte-level model checks the order and contents of every word, and checks that no word is left over at the end.

// File: rtl/rdp_pkg.sv
`timescale 1ns/1ps
package rdp_pkg;
  localparam int unsigned WORD_W     = 64;
  localparam int unsigned SLOT_W     = 16;
  localparam int unsigned CHUNK_W    = 32;
  localparam int unsigned WORD_BYTES = WORD_W / 8;
  localparam int unsigned CNT_W      = $clog2(WORD_BYTES) + 1;
  localparam int unsigned NB_W       = $clog2(CHUNK_W / 8) + 1;

  typedef enum logic [1:0] {
    RES_10  = 2'b00,
    RES_12  = 2'b01,
    RES_14  = 2'b10,
    RES_14X = 2'b11
  } res_e;

  typedef struct packed {
    logic             vld;
    logic             eol;
    logic [CNT_W-1:0] nbytes;
    logic [WORD_W-1:0] data;
  } word_t;
endpackage

// File: rtl/rdp_reset_sync.sv
`timescale 1ns/1ps
module rdp_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/rdp_pair_former.sv
`timescale 1ns/1ps
// Turns one pixel pair of one row into a 3-byte or 4-byte unit.
module rdp_pair_former
  import rdp_pkg::*;
#(
  parameter int unsigned PACK_W = 12,
  parameter int unsigned LOW_W  = 10,
  parameter int unsigned FULL_W = 14
) (
  input  res_e              mode,
  input  logic [SLOT_W-1:0] pix0,
  input  logic [SLOT_W-1:0] pix1,
  output logic [CHUNK_W-1:0] chunk,
  output logic [NB_W-1:0]    nbytes
);
  localparam int unsigned SHIFT_W  = PACK_W - LOW_W;
  localparam int unsigned PAD_W    = CHUNK_W - 3 * 8;
  localparam logic [SLOT_W-1:0] FULL_MASK = SLOT_W'((32'd1 << FULL_W) - 1);

  logic [SLOT_W-1:0] m0, m1;
  logic [PACK_W-1:0] a, b;

  always_comb begin
    m0 = pix0 & FULL_MASK;
    m1 = pix1 & FULL_MASK;
    a  = '0;
    b  = '0;
    unique case (mode)
      RES_10: begin
        a = {m0[LOW_W-1:0], {SHIFT_W{1'b0}}};
        b = {m1[LOW_W-1:0], {SHIFT_W{1'b0}}};
      end
      RES_12: begin
        a = m0[PACK_W-1:0];
        b = m1[PACK_W-1:0];
      end
      default: begin
        a = '0;
        b = '0;
      end
    endcase

    if (mode == RES_10 || mode == RES_12) begin
      chunk  = {{PAD_W{1'b0}}, b[PACK_W-1:4], b[3:0], a[PACK_W-1:8], a[7:0]};
      nbytes = NB_W'(3);
    end else begin
      chunk  = {m1, m0};
      nbytes = NB_W'(4);
    end
  end
endmodule

// File: rtl/rdp_lane_packer.sv
`timescale 1ns/1ps
// Gathers units of one row into 64-bit words; flushes at end of line.
module rdp_lane_packer
  import rdp_pkg::*;
#(
  parameter int unsigned PARITY = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_valid,
  input  logic              beat_eol,
  input  logic [CHUNK_W-1:0] chunk,
  input  logic [NB_W-1:0]    nbytes,
  output word_t             out_word,
  output logic              out_par
);
  localparam int unsigned WIDE_W = WORD_W + CHUNK_W;
  localparam int unsigned FILL_W = CNT_W - 1;

  logic [WORD_W-1:0] acc_q, acc_d;
  logic [FILL_W-1:0] fill_q, fill_d;
  word_t             pend_q, pend_d;
  word_t             out_q, out_d;
  word_t             gen_a, gen_b;
  logic [WIDE_W-1:0] wide;
  logic [CNT_W-1:0]  total, rem;
  logic              acc_en;

  // next-state
  always_comb begin
    wide   = {{CHUNK_W{1'b0}}, acc_q} | ({{WORD_W{1'b0}}, chunk} << {fill_q, 3'b000});
    total  = {1'b0, fill_q} + CNT_W'(nbytes);
    rem    = total - CNT_W'(WORD_BYTES);
    gen_a  = '0;
    gen_b  = '0;
    acc_d  = acc_q;
    fill_d = fill_q;
    acc_en = beat_valid;

    if (beat_valid) begin
      if (total >= CNT_W'(WORD_BYTES)) begin
        gen_a.vld    = 1'b1;
        gen_a.nbytes = CNT_W'(WORD_BYTES);
        gen_a.data   = wide[WORD_W-1:0];
        gen_a.eol    = beat_eol && (rem == '0);
        if (beat_eol) begin
          if (rem != '0) begin
            gen_b.vld    = 1'b1;
            gen_b.eol    = 1'b1;
            gen_b.nbytes = rem;
            gen_b.data   = {{(WORD_W-CHUNK_W){1'b0}}, wide[WIDE_W-1:WORD_W]};
          end
          acc_d  = '0;
          fill_d = '0;
        end else begin
          acc_d  = {{(WORD_W-CHUNK_W){1'b0}}, wide[WIDE_W-1:WORD_W]};
          fill_d = rem[FILL_W-1:0];
        end
      end else if (beat_eol) begin
        gen_a.vld    = 1'b1;
        gen_a.eol    = 1'b1;
        gen_a.nbytes = total;
        gen_a.data   = wide[WORD_W-1:0];
        acc_d        = '0;
        fill_d       = '0;
      end else begin
        acc_d  = wide[WORD_W-1:0];
        fill_d = total[FILL_W-1:0];
      end
    end

    // A held remainder always leaves first; a pending slot exists only on
    // the cycle after a line end, when at most one new word can form.
    if (pend_q.vld) begin
      out_d  = pend_q;
      pend_d = gen_a;
    end else begin
      out_d  = gen_a;
      pend_d = gen_b;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      fill_q <= '0;
    end else if (acc_en) begin
      acc_q  <= acc_d;
      fill_q <= fill_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      out_q  <= '0;
    end else begin
      pend_q.vld <= pend_d.vld;
      out_q.vld  <= out_d.vld;
      if (pend_d.vld) begin
        pend_q.eol    <= pend_d.eol;
        pend_q.nbytes <= pend_d.nbytes;
        pend_q.data   <= pend_d.data;
      end
      if (out_d.vld) begin
        out_q.eol    <= out_d.eol;
        out_q.nbytes <= out_d.nbytes;
        out_q.data   <= out_d.data;
      end
    end
  end

  assign out_word = out_q;
  assign out_par  = 1'(PARITY);
endmodule

// File: rtl/row_deinterleave_packer.sv
`timescale 1ns/1ps
module row_deinterleave_packer
  import rdp_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              in_valid,
  input  logic              in_eol,
  input  logic [WORD_W-1:0] in_data,
  output logic              ev_valid,
  output logic              ev_eol,
  output logic [CNT_W-1:0]  ev_bytes,
  output logic [WORD_W-1:0] ev_data,
  output logic              ev_par,
  output logic              od_valid,
  output logic              od_eol,
  output logic [CNT_W-1:0]  od_bytes,
  output logic [WORD_W-1:0] od_data,
  output logic              od_par
);
  localparam int unsigned LANES  = 2;
  localparam int unsigned LANE_W = WORD_W / LANES;

  logic  rst_sync_n;
  res_e  mode_e;
  word_t lane_word [LANES];
  logic  lane_par  [LANES];

  assign mode_e = res_e'(mode);

  rdp_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [CHUNK_W-1:0] chunk;
    logic [NB_W-1:0]    nbytes;

    rdp_pair_former u_form (
      .mode   (mode_e),
      .pix0   (in_data[g*LANE_W +: SLOT_W]),
      .pix1   (in_data[g*LANE_W+SLOT_W +: SLOT_W]),
      .chunk  (chunk),
      .nbytes (nbytes)
    );

    rdp_lane_packer #(.PARITY(g)) u_pack (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .beat_valid (in_valid),
      .beat_eol   (in_eol),
      .chunk      (chunk),
      .nbytes     (nbytes),
      .out_word   (lane_word[g]),
      .out_par    (lane_par[g])
    );
  end

  assign ev_valid = lane_word[0].vld;
  assign ev_eol   = lane_word[0].eol;
  assign ev_bytes = lane_word[0].nbytes;
  assign ev_data  = lane_word[0].data;
  assign ev_par   = lane_par[0];
  assign od_valid = lane_word[1].vld;
  assign od_eol   = lane_word[1].eol;
  assign od_bytes = lane_word[1].nbytes;
  assign od_data  = lane_word[1].data;
  assign od_par   = lane_par[1];
endmodule

// File: rtl/rdp_checker.sv
`timescale 1ns/1ps
module rdp_checker
  import rdp_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             ev_valid,
  input logic             ev_eol,
  input logic [CNT_W-1:0] ev_bytes,
  input logic             od_valid,
  input logic             od_eol,
  input logic [CNT_W-1:0] od_bytes
);
  assert_lanes_lockstep_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid == od_valid) && (!ev_valid || (ev_eol == od_eol && ev_bytes == od_bytes)));

  assert_full_unless_eol_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_eol) |-> (ev_bytes == CNT_W'(WORD_BYTES)));

  assert_count_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> (ev_bytes != '0 && ev_bytes <= CNT_W'(WORD_BYTES)));

  assert_no_spontaneous_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> ($past(in_valid) || $past(in_valid, 2)));
endmodule

bind row_deinterleave_packer rdp_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .ev_valid (ev_valid),
  .ev_eol   (ev_eol),
  .ev_bytes (ev_bytes),
  .od_valid (od_valid),
  .od_eol   (od_eol),
  .od_bytes (od_bytes)
);

// File: tb/tb_row_deinterleave_packer.sv
`timescale 1ns/1ps
module tb_row_deinterleave_packer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode;
  logic        in_valid, in_eol;
  logic [63:0] in_data;
  logic        ev_valid, ev_eol, ev_par, od_valid, od_eol, od_par;
  logic [3:0]  ev_bytes, od_bytes;
  logic [63:0] ev_data, od_data;

  int errs = 0;
  int checks = 0;
  bit mon_en = 1'b0;
  bit done = 1'b0;

  logic [7:0]  lbuf [2][16];
  int          lcnt [2];
  logic [68:0] exp0 [$];
  logic [68:0] exp1 [$];
  string       tag0 [$];
  string       tag1 [$];

  always #4 clk = ~clk; // 125 MHz

  row_deinterleave_packer dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .in_valid(in_valid), .in_eol(in_eol),
    .in_data(in_data),
    .ev_valid(ev_valid), .ev_eol(ev_eol), .ev_bytes(ev_bytes), .ev_data(ev_data), .ev_par(ev_par),
    .od_valid(od_valid), .od_eol(od_eol), .od_bytes(od_bytes), .od_data(od_data), .od_par(od_par)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [68:0] act, input logic [68:0] expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // unit of one pixel pair, from the requirement text (R3, R4, R5)
  function automatic logic [31:0] unit_of(input logic [1:0] m, input logic [15:0] p0,
                                          input logic [15:0] p1, output int nb);
    logic [11:0] a, b;
    if (m >= 2) begin
      nb = 4;
      return {2'b00, p1[13:0], 2'b00, p0[13:0]};
    end
    if (m == 0) begin a = {p0[9:0], 2'b00}; b = {p1[9:0], 2'b00}; end
    else        begin a = p0[11:0];         b = p1[11:0];         end
    nb = 3;
    return {8'h00, b[11:4], b[3:0], a[11:8], a[7:0]};
  endfunction

  task automatic push_word(input int lane, input bit eol, input int n);
    logic [63:0] d = '0;
    for (int i = 0; i < n; i++) d[i*8 +: 8] = lbuf[lane][i];
    for (int i = n; i < lcnt[lane]; i++) lbuf[lane][i-n] = lbuf[lane][i];
    lcnt[lane] -= n;
    if (lane == 0) begin exp0.push_back({eol, 4'(n), d}); tag0.push_back(eol ? "R7" : "R6"); end
    else           begin exp1.push_back({eol, 4'(n), d}); tag1.push_back(eol ? "R7" : "R6"); end
  endtask

  task automatic model_beat(input logic [1:0] m, input bit eol, input logic [63:0] d);
    for (int lane = 0; lane < 2; lane++) begin
      int nb;
      logic [31:0] u = unit_of(m, d[lane*32 +: 16], d[lane*32+16 +: 16], nb);
      for (int i = 0; i < nb; i++) begin
        lbuf[lane][lcnt[lane]] = u[i*8 +: 8];
        lcnt[lane]++;
      end
      if (!eol) begin
        if (lcnt[lane] >= 8) push_word(lane, 1'b0, 8);
      end else begin
        while (lcnt[lane] > 8) push_word(lane, 1'b0, 8);
        push_word(lane, 1'b1, lcnt[lane]);
      end
    end
  endtask

  task automatic beat(input logic [1:0] m, input bit eol, input logic [63:0] d);
    @(negedge clk);
    mode = m; in_valid = 1'b1; in_eol = eol; in_data = d;
    model_beat(m, eol, d);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; in_eol = 1'($urandom); in_data = {$urandom, $urandom};
  endtask

  task automatic mon_lane(input int lane, input logic v, input logic e, input logic [3:0] n,
                          input logic [63:0] d, input logic p);
    logic [68:0] x;
    string t;
    if (!v) return;
    check(p == 1'(lane), "R11", "parity tag", 69'(p), 69'(lane));
    if (lane == 0 && exp0.size() == 0 || lane == 1 && exp1.size() == 0) begin
      check(1'b0, "R10", "unexpected word", {e, n, d}, '0);
      return;
    end
    if (lane == 0) begin x = exp0.pop_front(); t = tag0.pop_front(); end
    else           begin x = exp1.pop_front(); t = tag1.pop_front(); end
    check({e, n, d} == x, t, $sformatf("lane%0d word", lane), {e, n, d}, x);
  endtask

  always @(negedge clk) begin
    if (mon_en) begin
      check(ev_valid == od_valid, "R11", "lane lockstep", 69'(ev_valid), 69'(od_valid));
      mon_lane(0, ev_valid, ev_eol, ev_bytes, ev_data, ev_par);
      mon_lane(1, od_valid, od_eol, od_bytes, od_data, od_par);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL R9 watchdog expired: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0051_7E5D));
    lcnt[0] = 0; lcnt[1] = 0;
    rst_n = 1'b0; mode = 2'd1; in_valid = 1'b0; in_eol = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    check(!ev_valid && !od_valid, "R1", "valid in reset", 69'({ev_valid, od_valid}), '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!ev_valid && !od_valid, "R1", "valid after release", 69'({ev_valid, od_valid}), '0);
    mon_en = 1'b1;

    // R2 / R3: 14-bit, two beats end exactly on a full word
    beat(2'd2, 1'b0, 64'h0555_0AAA_3FFF_C001);
    beat(2'd2, 1'b1, 64'h0CCC_0BBB_FFFF_1234);
    idle();
    check(ev_data == 64'h3FFF_1234_3FFF_0001 && ev_bytes == 4'd8 && ev_eol,
          "R3", "14-bit even word", {ev_eol, ev_bytes, ev_data}, {1'b1, 4'd8, 64'h3FFF_1234_3FFF_0001});
    check(od_data == 64'h0CCC_0BBB_0555_0AAA, "R2", "odd slots", 69'(od_data), 69'(64'h0CCC_0BBB_0555_0AAA));

    // R4: 12-bit single-beat line
    beat(2'd1, 1'b1, 64'h0000_0000_1234_FABC);
    idle();
    check(ev_data == 64'h0023_4ABC && ev_bytes == 4'd3, "R4", "12-bit pack",
          {ev_eol, ev_bytes, ev_data}, {1'b1, 4'd3, 64'h0023_4ABC});

    // R5: 10-bit single-beat line
    beat(2'd0, 1'b1, 64'h0000_0000_0001_03FF);
    idle();
    check(ev_data == 64'h0000_4FFC && ev_bytes == 4'd3, "R5", "10-bit pack",
          {ev_eol, ev_bytes, ev_data}, {1'b1, 4'd3, 64'h0000_4FFC});

    // R10: idle with garbage gives nothing
    idle();
    check(!ev_valid && !od_valid, "R10", "idle output", 69'({ev_valid, od_valid}), '0);

    // R8: 9-byte line
    for (int i = 0; i < 3; i++) beat(2'd1, i == 2, {$urandom, $urandom});
    idle();
    check(ev_valid && !ev_eol && ev_bytes == 4'd8, "R8", "full word first",
          {ev_valid, ev_eol, ev_bytes}, {1'b1, 1'b0, 4'd8});
    idle();
    check(ev_valid && ev_eol && ev_bytes == 4'd1, "R8", "remainder next cycle",
          {ev_valid, ev_eol, ev_bytes}, {1'b1, 1'b1, 4'd1});
    idle();

    // R9: remainder meets a one-beat line
    for (int i = 0; i < 3; i++) beat(2'd1, i == 2, {$urandom, $urandom});
    beat(2'd1, 1'b1, {$urandom, $urandom});
    check(ev_valid && !ev_eol && ev_bytes == 4'd8, "R9", "full word",
          {ev_valid, ev_eol, ev_bytes}, {1'b1, 1'b0, 4'd8});
    idle();
    check(ev_valid && ev_eol && ev_bytes == 4'd1, "R9", "held remainder",
          {ev_valid, ev_eol, ev_bytes}, {1'b1, 1'b1, 4'd1});
    idle();
    check(ev_valid && ev_eol && ev_bytes == 4'd3, "R9", "new short line",
          {ev_valid, ev_eol, ev_bytes}, {1'b1, 1'b1, 4'd3});

    // random lines
    for (int ln = 0; ln < 400; ln++) begin
      logic [1:0] m = 2'($urandom);
      int len = 1 + int'($urandom % 10);
      for (int b = 0; b < len; b++) begin
        if ($urandom % 4 == 0) idle();
        beat(m, b == len - 1, {$urandom, $urandom});
      end
    end
    repeat (6) idle();
    check(exp0.size() == 0 && exp1.size() == 0, "R9", "words left undelivered",
          69'(exp0.size() + exp1.size()), '0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule